// File: doc/BRIEF.md
# Word Aligner with Synchronization Hysteresis

This block takes a received parallel stream, 10 or 20 bits per clock, and finds the symbol boundary in it. Each incoming word is held for one cycle, and the block searches the two-word window {current word, previous word} for a fixed alignment pattern at every bit offset from 0 to W-1. The word that starts at the chosen offset is presented on the output one clock later. Bit 0 of every input word is the earliest received bit.

In automatic mode, a hysteresis machine watches the pattern detections and a per-word bad-code indication from the downstream decoder. The indication is "code not valid" or "disparity error". While the boundary is being acquired, it follows the most recent detection. Once sync is declared, the boundary is frozen. Two further modes share the datapath. In slip mode, each rising edge of a slip strobe advances the boundary by one bit. In manual mode, a rising edge of a request arms the block to lock onto the next pattern. A run-length monitor flags any word in which a run of identical bits grows past a limit. Runs are counted across word boundaries.

State machine states:
- `ST_ACQ`: automatic acquisition, counting detections.
- `ST_LOCK`: in sync with no pending errors.
- `ST_RECOVER`: in sync with one or more pending errors.
- `ST_SLIP`: slip mode.
- `ST_IDLE`: manual mode, waiting for a request.
- `ST_ARMED`: manual mode, waiting for the next pattern.

Transitions:
- **Home:** a mode that does not fit the state sends it to `ST_SLIP`, `ST_IDLE` or `ST_ACQ`.
- **Acquire:** `ST_ACQ` to `ST_LOCK` on the ACQ_NUM-th detection.
- **First error:** `ST_LOCK` to `ST_RECOVER`.
- **Recover:** `ST_RECOVER` to `ST_LOCK` when the error count returns to zero.
- **Lose:** `ST_LOCK`/`ST_RECOVER` to `ST_ACQ` (automatic) or `ST_IDLE` (manual) when the error count reaches LOSE_NUM.
- **Arm:** `ST_IDLE`/`ST_LOCK`/`ST_RECOVER` to `ST_ARMED` on a request edge in manual mode.
- **Capture:** `ST_ARMED` to `ST_LOCK` on a detection.

Top module: `wa_sync_top`

## Requirements
- R1: While reset is asserted, `dout_o`, `sync_o` and `runlen_err_o` are 0 and the boundary offset is 0.
- R2: The pattern is detected at any offset k in 0..W-1 of the window {din_i, previous din_i}. In `ST_ACQ`, a detection moves the boundary to k in the same cycle. `dout_o` after a clock edge equals window bits [k+W-1:k] for the boundary in force after that edge, so the pattern word itself appears on `dout_o`.
- R3: In automatic mode (`mode_i`=0), `sync_o` rises on the clock edge of the ACQ_NUM-th detection since entering `ST_ACQ`, and not before.
- R4: While in sync, a word is bad when `code_valid_i`=0 or `disp_err_i`=1. When the error count reaches LOSE_NUM, `sync_o` drops and acquisition restarts with a zero detection count.
- R5: In `ST_RECOVER`, every RECOV_NUM consecutive good words decrement the error count, and a bad word restarts that run. When the count returns to 0 the machine is back in full lock, so a fresh LOSE_NUM bad words are needed to lose sync.
- R6: While `sync_o` is 1, the boundary does not move, even if the pattern appears at another offset.
- R7: In slip mode (`mode_i`=1), each rising edge of `slip_i` advances the offset by one bit (modulo W), dropping the earliest bit. A held-high `slip_i` has no further effect, and `sync_o` stays 0.
- R8: In manual mode (`mode_i`=2), patterns are ignored until a rising edge of `align_req_i`. The next detection after that edge sets the boundary and raises `sync_o` on that edge. A held-high request does not re-arm, and a new rising edge while in sync drops `sync_o` and re-arms.
- R9: `runlen_err_o` is 1 for the cycle after any input word during which a run of identical bits exceeds RUN_MAX. Runs continue across word boundaries.
- R10: `mode_i` encodings are 0 = automatic, 1 = slip, 2 = manual (3 acts as automatic). A mode that does not fit the current state sends the machine to that mode's home state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered parallel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Alignment mode select (R10) |
| din_i | input | W | Raw received word, bit 0 earliest |
| slip_i | input | 1 | Slip strobe, rising-edge active |
| align_req_i | input | 1 | Manual alignment request, rising-edge active |
| code_valid_i | input | 1 | Current word decoded as a valid code |
| disp_err_i | input | 1 | Current word has a disparity error |
| dout_o | output | W | Aligned word |
| sync_o | output | 1 | Synchronization status |
| runlen_err_o | output | 1 | Run-length violation for the previous word |

## Verification
The bench builds the block with W=10, a 10-bit pattern with a single five-ones run, ACQ_NUM, LOSE_NUM and RECOV_NUM all 3, and RUN_MAX=5. With these small counts, a single short test reaches every hysteresis boundary: one detection short of sync, one bad word short of loss, and a recovery that resets the error budget. With a run limit of 5, runs of exactly 5 and 6 can be placed inside one word and across a word boundary. The stream is sent with a non-zero bit offset, so every detection straddles two input words.

// File: rtl/wa_pkg.sv
`timescale 1ns/1ps
package wa_pkg;

    typedef enum logic [1:0] {
        MODE_AUTO   = 2'd0,
        MODE_SLIP   = 2'd1,
        MODE_MANUAL = 2'd2
    } wa_mode_e;

    typedef enum logic [2:0] {
        ST_ACQ,
        ST_LOCK,
        ST_RECOVER,
        ST_SLIP,
        ST_IDLE,
        ST_ARMED
    } wa_state_e;

endpackage

// File: rtl/wa_pattern_search.sv
`timescale 1ns/1ps
module wa_pattern_search #(
    parameter int W = 10,
    parameter int PLEN = 10,
    parameter logic [PLEN-1:0] PATTERN = '0
) (
    input  logic [2*W-1:0]         window,
    output logic                   hit,
    output logic [$clog2(W)-1:0]   hit_off
);
    localparam int WIN  = 2 * W;
    localparam int OFFW = $clog2(W);

    logic [W-1:0] match;

    for (genvar k = 0; k < W; k++) begin : g_off
        if (k + PLEN <= WIN) begin : g_fit
            assign match[k] = (window[k +: PLEN] == PATTERN);
        end else begin : g_nofit
            assign match[k] = 1'b0;
        end
    end

    // lowest offset wins
    always_comb begin
        hit_off = '0;
        for (int k = W - 1; k >= 0; k--) begin
            if (match[k]) hit_off = OFFW'(k);
        end
        hit = |match;
    end

endmodule

// File: rtl/wa_run_length.sv
`timescale 1ns/1ps
module wa_run_length #(
    parameter int W = 10,
    parameter int RUN_MAX = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic         err_o
);
    localparam int LW = 7;

    logic          bit_q, bit_n;
    logic [LW-1:0] len_q, len_n;
    logic          viol;

    always_comb begin
        bit_n = bit_q;
        len_n = len_q;
        viol  = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (din[i] == bit_n) begin
                if (len_n <= LW'(RUN_MAX)) len_n = len_n + 1'b1;
            end else begin
                bit_n = din[i];
                len_n = LW'(1);
            end
            if (len_n > LW'(RUN_MAX)) viol = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= 1'b0;
            len_q <= '0;
            err_o <= 1'b0;
        end else begin
            bit_q <= bit_n;
            len_q <= len_n;
            err_o <= viol;
        end
    end

endmodule

// File: rtl/wa_sync_fsm.sv
`timescale 1ns/1ps
module wa_sync_fsm
    import wa_pkg::*;
#(
    parameter int W = 10,
    parameter int ACQ_NUM = 3,
    parameter int LOSE_NUM = 3,
    parameter int RECOV_NUM = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  wa_mode_e             mode,
    input  logic                 hit,
    input  logic [$clog2(W)-1:0] hit_off,
    input  logic                 slip_rise,
    input  logic                 req_rise,
    input  logic                 bad,
    output logic [$clog2(W)-1:0] bnd_q,
    output logic [$clog2(W)-1:0] bnd_n,
    output logic                 sync_o
);
    localparam int OFFW = $clog2(W);
    localparam int AW   = $clog2(ACQ_NUM + 1);
    localparam int EW   = $clog2(LOSE_NUM + 1);
    localparam int GW   = $clog2(RECOV_NUM + 1);

    wa_state_e     st_q, st_n;
    logic [AW-1:0] acq_q, acq_n;
    logic [EW-1:0] err_q, err_n;
    logic [GW-1:0] good_q, good_n;
    logic          fits;
    wa_state_e     home;

    always_comb begin
        unique case (mode)
            MODE_SLIP:   home = ST_SLIP;
            MODE_MANUAL: home = ST_IDLE;
            default:     home = ST_ACQ;
        endcase
        unique case (st_q)
            ST_SLIP:             fits = (mode == MODE_SLIP);
            ST_IDLE, ST_ARMED:   fits = (mode == MODE_MANUAL);
            ST_LOCK, ST_RECOVER: fits = (mode != MODE_SLIP);
            default:             fits = (mode != MODE_SLIP) && (mode != MODE_MANUAL);
        endcase
    end

    // next state
    always_comb begin
        st_n   = st_q;
        acq_n  = acq_q;
        err_n  = err_q;
        good_n = good_q;
        bnd_n  = bnd_q;
        if (!fits) begin
            st_n   = home;
            acq_n  = '0;
            err_n  = '0;
            good_n = '0;
        end else begin
            unique case (st_q)
                ST_SLIP: begin
                    if (slip_rise)
                        bnd_n = (bnd_q == OFFW'(W - 1)) ? '0 : bnd_q + 1'b1;
                end
                ST_IDLE: begin
                    if (req_rise) st_n = ST_ARMED;
                end
                ST_ARMED: begin
                    if (hit) begin
                        bnd_n  = hit_off;
                        st_n   = ST_LOCK;
                        err_n  = '0;
                        good_n = '0;
                    end
                end
                ST_ACQ: begin
                    if (hit) begin
                        bnd_n = hit_off;
                        if (int'(acq_q) + 1 >= ACQ_NUM) begin
                            st_n   = ST_LOCK;
                            acq_n  = '0;
                            err_n  = '0;
                            good_n = '0;
                        end else begin
                            acq_n = acq_q + 1'b1;
                        end
                    end
                end
                ST_LOCK: begin
                    if (mode == MODE_MANUAL && req_rise) begin
                        st_n = ST_ARMED;
                    end else if (bad) begin
                        good_n = '0;
                        if (LOSE_NUM <= 1) begin
                            st_n  = home;
                            acq_n = '0;
                            err_n = '0;
                        end else begin
                            st_n  = ST_RECOVER;
                            err_n = EW'(1);
                        end
                    end
                end
                ST_RECOVER: begin
                    if (mode == MODE_MANUAL && req_rise) begin
                        st_n   = ST_ARMED;
                        err_n  = '0;
                        good_n = '0;
                    end else if (bad) begin
                        good_n = '0;
                        if (int'(err_q) + 1 >= LOSE_NUM) begin
                            st_n  = home;
                            acq_n = '0;
                            err_n = '0;
                        end else begin
                            err_n = err_q + 1'b1;
                        end
                    end else if (int'(good_q) + 1 >= RECOV_NUM) begin
                        good_n = '0;
                        err_n  = err_q - 1'b1;
                        if (err_q == EW'(1)) st_n = ST_LOCK;
                    end else begin
                        good_n = good_q + 1'b1;
                    end
                end
                default: st_n = ST_ACQ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_ACQ;
            acq_q  <= '0;
            err_q  <= '0;
            good_q <= '0;
            bnd_q  <= '0;
        end else begin
            st_q   <= st_n;
            acq_q  <= acq_n;
            err_q  <= err_n;
            good_q <= good_n;
            bnd_q  <= bnd_n;
        end
    end

    // outputs
    always_comb begin
        sync_o = (st_q == ST_LOCK) || (st_q == ST_RECOVER);
    end

endmodule

// File: rtl/wa_sync_top.sv
`timescale 1ns/1ps
module wa_sync_top
    import wa_pkg::*;
#(
    parameter int W = 10,
    parameter int PLEN = 10,
    parameter logic [PLEN-1:0] PATTERN = PLEN'(10'h17C),
    parameter int ACQ_NUM = 3,
    parameter int LOSE_NUM = 3,
    parameter int RECOV_NUM = 3,
    parameter int RUN_MAX = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode_i,
    input  logic [W-1:0] din_i,
    input  logic         slip_i,
    input  logic         align_req_i,
    input  logic         code_valid_i,
    input  logic         disp_err_i,
    output logic [W-1:0] dout_o,
    output logic         sync_o,
    output logic         runlen_err_o
);
    localparam int OFFW = $clog2(W);

    logic [W-1:0]    prev_q;
    logic            slip_q, req_q;
    logic [2*W-1:0]  window;
    logic            hit;
    logic [OFFW-1:0] hit_off;
    logic [OFFW-1:0] bnd_q, bnd_n;
    logic            slip_rise, req_rise, bad;

    assign window    = {din_i, prev_q};
    assign slip_rise = slip_i & ~slip_q;
    assign req_rise  = align_req_i & ~req_q;
    assign bad       = ~code_valid_i | disp_err_i;

    wa_pattern_search #(.W(W), .PLEN(PLEN), .PATTERN(PATTERN)) u_search (
        .window  (window),
        .hit     (hit),
        .hit_off (hit_off)
    );

    wa_sync_fsm #(
        .W(W), .ACQ_NUM(ACQ_NUM), .LOSE_NUM(LOSE_NUM), .RECOV_NUM(RECOV_NUM)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (wa_mode_e'(mode_i)),
        .hit       (hit),
        .hit_off   (hit_off),
        .slip_rise (slip_rise),
        .req_rise  (req_rise),
        .bad       (bad),
        .bnd_q     (bnd_q),
        .bnd_n     (bnd_n),
        .sync_o    (sync_o)
    );

    wa_run_length #(.W(W), .RUN_MAX(RUN_MAX)) u_run (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din_i),
        .err_o (runlen_err_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            slip_q <= 1'b0;
            req_q  <= 1'b0;
            dout_o <= '0;
        end else begin
            prev_q <= din_i;
            slip_q <= slip_i;
            req_q  <= align_req_i;
            dout_o <= window[bnd_n +: W];
        end
    end

endmodule

// File: rtl/wa_sync_chk.sv
`timescale 1ns/1ps
module wa_sync_chk #(
    parameter int W = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           mode_i,
    input logic                 sync_o,
    input logic [$clog2(W)-1:0] bnd,
    input logic                 hit,
    input logic                 slip_rise
);
    p_bnd_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(bnd) < W);

    p_sync_needs_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_o) |-> $past(hit));

    p_frozen_bnd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |=> $stable(bnd));

    p_slip_nosync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd1) |=> !sync_o);

    p_slip_only_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd1 && !slip_rise) |=> $stable(bnd));

endmodule

bind wa_sync_top wa_sync_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .sync_o    (sync_o),
    .bnd       (bnd_q),
    .hit       (hit),
    .slip_rise (slip_rise)
);

// File: tb/sim_wa_sync_top.sv
`timescale 1ns/1ps
module sim_wa_sync_top;
    localparam int W = 10;
    localparam int RUN_MAX = 5;
    localparam logic [W-1:0] PAT  = 10'h17C;
    localparam logic [W-1:0] FILL = 10'h155;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [W-1:0] din = '0;
    logic slip = 1'b0, req = 1'b0, cv = 1'b1, de = 1'b0;
    logic [W-1:0] dout;
    logic sync, rl_err;

    always #2 clk = ~clk;

    wa_sync_top #(
        .W(W), .PLEN(W), .PATTERN(PAT), .ACQ_NUM(3), .LOSE_NUM(3),
        .RECOV_NUM(3), .RUN_MAX(RUN_MAX)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .din_i(din), .slip_i(slip),
        .align_req_i(req), .code_valid_i(cv), .disp_err_i(de),
        .dout_o(dout), .sync_o(sync), .runlen_err_o(rl_err)
    );

    int n_run = 0, n_bad = 0;
    logic [W-1:0] cur_rx, prev_rx;
    logic rl_bit; int rl_len; logic exp_rl;
    logic [2*W-1:0] pend; int npend;
    logic [W-1:0] last_a, exp_a;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_rl(input logic [W-1:0] rx);
        exp_rl = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (rx[i] == rl_bit) begin
                if (rl_len <= RUN_MAX) rl_len++;
            end else begin
                rl_bit = rx[i];
                rl_len = 1;
            end
            if (rl_len > RUN_MAX) exp_rl = 1'b1;
        end
    endtask

    function automatic logic [W-1:0] slice_at(input int k);
        logic [2*W-1:0] w;
        w = {cur_rx, prev_rx};
        return w[k +: W];
    endfunction

    task automatic push_rx(input logic [W-1:0] rx);
        prev_rx = cur_rx;
        cur_rx  = rx;
        din     = rx;
        model_rl(rx);
        @(posedge clk);
        #1;
    endtask

    task automatic send_a(input logic [W-1:0] a);
        logic [W-1:0] rx;
        pend  = pend | ({{W{1'b0}}, a} << npend);
        rx    = pend[W-1:0];
        pend  = pend >> W;
        exp_a = last_a;
        last_a = a;
        push_rx(rx);
    endtask

    task automatic do_reset(input logic [1:0] m, input int s);
        rst_n = 1'b0; mode = m; din = '0; slip = 0; req = 0; cv = 1; de = 0;
        rl_bit = 0; rl_len = 0; cur_rx = '0; prev_rx = '0;
        pend = '0; npend = s; last_a = '0; exp_a = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic acquire();
        send_a(FILL); send_a(PAT); send_a(FILL); send_a(PAT);
        send_a(FILL); send_a(PAT);
        check("R3 one detection short of sync", 32'(sync), 32'd0);
        send_a(FILL);
        check("R3 sync after third detection", 32'(sync), 32'd1);
        check("R2 pattern word on output", 32'(dout), 32'(PAT));
    endtask

    initial begin
        #(4 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));

        // R1 reset state, R10 automatic mode 0
        do_reset(2'd0, 2);
        check("R1 dout", 32'(dout), 32'd0);
        check("R1 sync", 32'(sync), 32'd0);
        check("R1 runlen", 32'(rl_err), 32'd0);

        // R2/R3 acquisition at offset 2
        send_a(FILL); send_a(PAT); send_a(FILL);
        check("R2 first detection aligns output", 32'(dout), 32'(PAT));
        check("R3 no sync after one detection", 32'(sync), 32'd0);
        send_a(PAT); send_a(FILL); send_a(PAT);
        check("R3 one detection short of sync", 32'(sync), 32'd0);
        send_a(FILL);
        check("R3 sync after third detection", 32'(sync), 32'd1);
        check("R2 aligned pattern", 32'(dout), 32'(PAT));

        // R6 pattern at another offset while locked
        send_a((PAT << 3) | 10'b010);
        check("R6 dout frozen a", 32'(dout), 32'(exp_a));
        send_a((FILL & ~10'h7) | (PAT >> 7));
        check("R6 dout frozen b", 32'(dout), 32'(exp_a));
        send_a(FILL);
        check("R6 dout frozen c", 32'(dout), 32'(exp_a));
        check("R6 sync kept", 32'(sync), 32'd1);

        // random words in lock: R2 alignment and R9 run length
        for (int i = 0; i < 60; i++) begin
            send_a(W'($urandom));
            check("R2 random aligned word", 32'(dout), 32'(exp_a));
            check("R9 random run length", 32'(rl_err), 32'(exp_rl));
        end
        send_a(FILL);

        // R5 recover then R4 lose
        cv = 0; send_a(FILL); cv = 1;
        check("R5 one bad keeps sync", 32'(sync), 32'd1);
        send_a(FILL); send_a(FILL); send_a(FILL);
        de = 1; send_a(FILL); send_a(FILL); de = 0;
        check("R5 error count restored", 32'(sync), 32'd1);
        cv = 0; send_a(FILL); cv = 1;
        check("R4 third bad loses sync", 32'(sync), 32'd0);

        // reacquire, then partial recovery must not clear errors
        acquire();
        cv = 0; send_a(FILL); cv = 1;
        send_a(FILL); send_a(FILL);
        de = 1; send_a(FILL);
        check("R5 partial run no decrement", 32'(sync), 32'd1);
        send_a(FILL); de = 0;
        check("R4 lost with pending errors", 32'(sync), 32'd0);

        // R2 in acquisition the boundary follows the newest detection (offset 5)
        send_a(FILL);
        send_a((PAT << 3) | 10'b010);
        send_a((FILL & ~10'h7) | (PAT >> 7));
        check("R2 boundary follows newest detection", 32'(dout), 32'(PAT));
        check("R2 still acquiring", 32'(sync), 32'd0);

        // R9 directed run-length boundaries
        do_reset(2'd0, 0);
        push_rx(FILL);
        push_rx(10'h01F);
        check("R9 run of five no error", 32'(rl_err), 32'd0);
        push_rx(10'h03F);
        check("R9 run of six flagged", 32'(rl_err), 32'd1);
        push_rx(FILL);
        check("R9 clear after violation", 32'(rl_err), 32'd0);
        push_rx(10'h3E1);
        check("R9 five at word end", 32'(rl_err), 32'd0);
        push_rx(FILL);
        check("R9 run across word boundary", 32'(rl_err), 32'd1);

        // R7 bit slip, R10 mode 1
        do_reset(2'd1, 0);
        push_rx(W'($urandom));
        push_rx(W'($urandom));
        check("R7 offset zero initially", 32'(dout), 32'(slice_at(0)));
        slip = 1; push_rx(W'($urandom));
        check("R7 one slip", 32'(dout), 32'(slice_at(1)));
        push_rx(W'($urandom));
        check("R7 held slip no effect", 32'(dout), 32'(slice_at(1)));
        slip = 0; push_rx(W'($urandom));
        slip = 1; push_rx(W'($urandom));
        check("R7 second slip", 32'(dout), 32'(slice_at(2)));
        slip = 0;
        push_rx(PAT); push_rx(PAT); push_rx(PAT); push_rx(PAT);
        check("R7 no sync in slip mode", 32'(sync), 32'd0);
        check("R7 offset kept with patterns", 32'(dout), 32'(slice_at(2)));

        // R8 manual alignment, R10 mode 2
        do_reset(2'd2, 3);
        send_a(FILL); send_a(PAT); send_a(FILL); send_a(PAT); send_a(FILL);
        check("R8 pattern ignored without request", 32'(sync), 32'd0);
        check("R8 boundary untouched", 32'(dout), 32'(slice_at(0)));
        req = 1; send_a(FILL);
        check("R8 armed not synced", 32'(sync), 32'd0);
        send_a(PAT); send_a(FILL);
        check("R8 lock on next pattern", 32'(sync), 32'd1);
        check("R8 aligned pattern", 32'(dout), 32'(PAT));
        send_a(FILL);
        check("R8 held request no re-arm", 32'(sync), 32'd1);
        check("R8 aligned data", 32'(dout), 32'(exp_a));
        req = 0; send_a(FILL);
        req = 1; send_a(FILL);
        check("R8 new request re-arms", 32'(sync), 32'd0);
        req = 0;

        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule